// File: doc/BRIEF.md
# Microcontroller Mailbox Register Interface

This block sits between a host register port and a housekeeping microcontroller that exchanges single bytes. The host sees eight 32-bit words. The data word feeds a 16-byte transmit queue when written and drains a 16-byte receive queue when read. A status word reports the state of both queues. An interrupt word holds request flags and per-source enables.

On the microcontroller side, bytes leave through a valid/ready stream. A byte stays on `mc_tx_data` with `mc_tx_valid` high until the consumer raises `mc_tx_ready` on a clock edge; the consumer may hold the queue back for as long as it likes. Incoming bytes arrive on a second valid/ready stream whose `mc_rx_ready` is always high. The link cannot be stalled, so a byte that finds the receive queue full is discarded and the loss is latched in an overflow flag.

Host accesses last one cycle. A write takes effect at the clock edge where `bus_wr` is high. Read data is combinational from `bus_addr` while `bus_rd` is high, and a read of the data word removes the oldest receive byte at that edge.

Top module: `mcu_mailbox`

## Requirements
- R1: After reset both queues are empty, the status word reads 0x3, the interrupt word reads 0x03, `irq` is low and `mc_tx_valid` is low.
- R2: `bus_addr` selects a word: 0 is interrupt, 1 is data, 2 is status. Words 3 to 7 read as zero, and writes to them change nothing.
- R3: A write to the data word appends `bus_wdata[15:8]` to the transmit queue. The other bits are ignored. A write made while the queue holds 16 bytes is dropped.
- R4: `mc_tx_valid` is high exactly when the transmit queue is not empty. The bytes come out in the order they were written, and `mc_tx_data` holds steady while valid is high and ready is low.
- R5: A read of the data word returns the oldest receive byte in bits [15:8], with all other bits zero, and removes that byte. A read while the receive queue is empty returns zero and changes nothing.
- R6: A byte that arrives on the receive stream while 16 bytes are held is dropped and sets status bit 3. The bit stays set until a status write with bit 3 equal to one. When a new drop and a clear fall on the same edge, the drop wins.
- R7: Status bits are live: bit 0 means the transmit queue is empty, bit 1 means it is not full, and bit 2 means the receive queue is not empty. Writing ones to bits 0 to 2 has no effect.
- R8: In the interrupt word, bits 3:0 mirror status bits 3:0 and are read-only. Bits 7:4 are enables in the same source order, written from `bus_wdata[7:4]`.
- R9: `irq` is high exactly when some interrupt word bit n (n from 0 to 3) and enable bit n+4 are both one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq | output | 1 | Interrupt request |
| mc_tx_valid | output | 1 | Transmit byte available |
| mc_tx_ready | input | 1 | Consumer takes the transmit byte |
| mc_tx_data | output | 8 | Transmit byte |
| mc_rx_valid | input | 1 | Receive byte offered |
| mc_rx_ready | output | 1 | Always high |
| mc_rx_data | input | 8 | Receive byte |

## Verification
On every cycle the assertions check four things: that the overflow flag latches, that it survives until an explicit clear, that a read of the empty receive queue returns zero, and that a stalled transmit byte stays put. Queue occupancy bounds and the refusal of a push into a full queue are checked there as well. Byte order through both queues, loss of the seventeenth byte, the interrupt-word layout and the mask combinations behind `irq` show up only in the bench's scenarios. Those scenarios compare values read back against values computed independently.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int BUS_W    = 32;
  localparam int BYTE_W   = 8;
  localparam int ADDR_W   = 3;
  localparam int BYTE_LSB = 8;
  localparam int NSRC     = 4;

  localparam logic [ADDR_W-1:0] A_INTR = 3'd0;
  localparam logic [ADDR_W-1:0] A_DATA = 3'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd2;

  localparam int F_OVF = 3;

  typedef struct packed {
    logic rx_ovf;
    logic rx_nempty;
    logic tx_nfull;
    logic tx_empty;
  } flags_t;
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;
  logic             do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R3 / R6: occupancy never exceeds the depth
  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  // R6: a push into a full queue without a pop leaves it full
  p_full_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> full);
endmodule

// File: rtl/mbox_regs.sv
module mbox_regs
  import mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              tx_empty,
  input  logic              tx_full,
  input  logic              rx_empty,
  input  logic [BYTE_W-1:0] rx_head,
  input  logic              rx_drop,
  output logic              tx_push,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              rx_pop,
  output logic              irq
);
  logic [NSRC-1:0] enable;
  logic            ovf;
  flags_t          fl;
  logic            clr_ovf;
  logic            unused_wbits;

  assign fl.tx_empty  = tx_empty;
  assign fl.tx_nfull  = !tx_full;
  assign fl.rx_nempty = !rx_empty;
  assign fl.rx_ovf    = ovf;

  assign tx_push = bus_wr && (bus_addr == A_DATA);
  assign tx_byte = bus_wdata[BYTE_LSB +: BYTE_W];
  assign rx_pop  = bus_rd && (bus_addr == A_DATA);
  assign clr_ovf = bus_wr && (bus_addr == A_STAT) && bus_wdata[F_OVF];
  assign unused_wbits = ^{bus_wdata[BUS_W-1:BYTE_LSB+BYTE_W], bus_wdata[2:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable <= '0;
      ovf    <= 1'b0;
    end else begin
      if (bus_wr && (bus_addr == A_INTR)) enable <= bus_wdata[NSRC +: NSRC];
      if (rx_drop)      ovf <= 1'b1;
      else if (clr_ovf) ovf <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_INTR: bus_rdata[2*NSRC-1:0] = {enable, fl};
      A_DATA: if (!rx_empty) bus_rdata[BYTE_LSB +: BYTE_W] = rx_head;
      A_STAT: bus_rdata[NSRC-1:0] = fl;
      default: bus_rdata = '0;
    endcase
  end

  assign irq = |(fl & enable);

  // R6: a drop always leaves the flag set
  p_ovf_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop |=> ovf);
  // R6: the flag only falls after an explicit clear
  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr_ovf) |=> ovf);
endmodule

// File: rtl/mcu_mailbox.sv
module mcu_mailbox
  import mbox_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [2:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              mc_tx_valid,
  input  logic              mc_tx_ready,
  output logic [7:0]        mc_tx_data,
  input  logic              mc_rx_valid,
  output logic              mc_rx_ready,
  input  logic [7:0]        mc_rx_data
);
  logic              tx_push, tx_empty, tx_full;
  logic              rx_pop, rx_empty, rx_full, rx_drop;
  logic [BYTE_W-1:0] tx_byte, rx_head;

  assign mc_rx_ready = 1'b1;
  assign rx_drop     = mc_rx_valid && rx_full;
  assign mc_tx_valid = !tx_empty;

  mbox_fifo #(.WIDTH(BYTE_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push(tx_push), .wdata(tx_byte),
    .pop(mc_tx_ready), .rdata(mc_tx_data),
    .empty(tx_empty), .full(tx_full)
  );

  mbox_fifo #(.WIDTH(BYTE_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push(mc_rx_valid), .wdata(mc_rx_data),
    .pop(rx_pop), .rdata(rx_head),
    .empty(rx_empty), .full(rx_full)
  );

  mbox_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_empty(tx_empty), .tx_full(tx_full),
    .rx_empty(rx_empty), .rx_head(rx_head), .rx_drop(rx_drop),
    .tx_push(tx_push), .tx_byte(tx_byte), .rx_pop(rx_pop),
    .irq(irq)
  );

  // R4: a stalled byte stays offered and unchanged
  p_tx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_tx_valid && !mc_tx_ready) |=> (mc_tx_valid && $stable(mc_tx_data)));
  // R5: reading the empty receive queue yields zero
  p_empty_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_DATA && rx_empty) |-> (bus_rdata == '0));
endmodule

// File: tb/mcu_mailbox_test.sv
module mcu_mailbox_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, mc_tx_valid, mc_rx_ready;
  logic        mc_tx_ready = 1'b0;
  logic [7:0]  mc_tx_data;
  logic        mc_rx_valid = 1'b0;
  logic [7:0]  mc_rx_data = '0;

  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  mcu_mailbox uut (.*);

  localparam int NV = 20;
  // {op[1:0], addr[2:0], data[31:0], expect[31:0]}; op 0 write, 1 read, 2 rx byte, 3 tx take
  localparam logic [68:0] VEC [NV] = '{
    {2'd1, 3'd2, 32'h0,        32'h3},
    {2'd1, 3'd0, 32'h0,        32'h3},
    {2'd0, 3'd0, 32'hFFFF_FFFF, 32'h0},
    {2'd1, 3'd0, 32'h0,        32'hF3},
    {2'd0, 3'd1, 32'h1234_A5CD, 32'h0},
    {2'd1, 3'd2, 32'h0,        32'h2},
    {2'd0, 3'd1, 32'h0000_3C00, 32'h0},
    {2'd3, 3'd0, 32'h0,        32'hA5},
    {2'd3, 3'd0, 32'h0,        32'h3C},
    {2'd1, 3'd2, 32'h0,        32'h3},
    {2'd2, 3'd0, 32'h5A,       32'h0},
    {2'd1, 3'd2, 32'h0,        32'h7},
    {2'd2, 3'd0, 32'h81,       32'h0},
    {2'd1, 3'd1, 32'h0,        32'h5A00},
    {2'd1, 3'd1, 32'h0,        32'h8100},
    {2'd1, 3'd1, 32'h0,        32'h0},
    {2'd1, 3'd2, 32'h0,        32'h3},
    {2'd0, 3'd2, 32'h7,        32'h0},
    {2'd1, 3'd2, 32'h0,        32'h3},
    {2'd1, 3'd5, 32'h0,        32'h0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [2:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [2:0] a, output logic [31:0] v);
    bus_rd = 1'b1; bus_addr = a;
    #1 v = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] b);
    mc_rx_valid = 1'b1; mc_rx_data = b;
    @(posedge clk); @(negedge clk);
    mc_rx_valid = 1'b0;
  endtask

  task automatic tx_take(output logic [7:0] b, output logic v);
    v = mc_tx_valid; b = mc_tx_data; mc_tx_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    mc_tx_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got 0x0 expected 0x1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  logic [31:0] rv;
  logic [7:0]  tb;
  logic        tv;
  logic [1:0]  op;
  logic [2:0]  va;
  logic [31:0] vd, ve;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 tx_valid", {31'b0, mc_tx_valid}, 32'h0);
    check("R1 rx_ready", {31'b0, mc_rx_ready}, 32'h1);

    // vector table: R2 R3 R4 R5 R7 R8
    for (int i = 0; i < NV; i++) begin
      {op, va, vd, ve} = VEC[i];
      case (op)
        2'd0: do_wr(va, vd);
        2'd1: begin do_rd(va, rv); check($sformatf("R2/R5/R7/R8 vec %0d", i), rv, ve); end
        2'd2: rx_push(vd[7:0]);
        default: begin
          tx_take(tb, tv);
          check($sformatf("R4 vec %0d valid", i), {31'b0, tv}, 32'h1);
          check($sformatf("R3 vec %0d byte", i), {24'b0, tb}, ve);
        end
      endcase
    end

    // R9 interrupt combinations (enables are all set; tx empty)
    check("R9 all enabled", {31'b0, irq}, 32'h1);
    do_wr(3'd0, 32'h0);
    check("R9 none enabled", {31'b0, irq}, 32'h0);
    do_wr(3'd0, 32'h40);
    check("R9 rx enable, rx empty", {31'b0, irq}, 32'h0);
    rx_push(8'h77);
    check("R9 rx enable, rx byte", {31'b0, irq}, 32'h1);
    do_rd(3'd1, rv);
    check("R5 pop", rv, 32'h7700);
    check("R9 after pop", {31'b0, irq}, 32'h0);

    // R2 reserved writes change nothing
    do_wr(3'd6, 32'hFFFF_FFFF);
    do_rd(3'd0, rv);
    check("R2 reserved write", rv, 32'h43);

    // R3 tx full: 17 writes, last dropped
    for (int i = 0; i < 17; i++) do_wr(3'd1, {16'h0, 8'(8'h10 + i), 8'h0});
    do_rd(3'd2, rv);
    check("R7 tx full status", rv, 32'h0);
    // R4 hold while stalled
    tb = mc_tx_data;
    repeat (3) @(negedge clk);
    check("R4 stall valid", {31'b0, mc_tx_valid}, 32'h1);
    check("R4 stall data", {24'b0, mc_tx_data}, {24'b0, tb});
    for (int i = 0; i < 16; i++) begin
      tx_take(tb, tv);
      check("R3 tx order", {23'b0, tv, tb}, {23'b0, 1'b1, 8'(8'h10 + i)});
    end
    check("R3 17th dropped", {31'b0, mc_tx_valid}, 32'h0);

    // R6 overflow
    for (int i = 0; i < 17; i++) rx_push(8'(8'h20 + i));
    do_rd(3'd2, rv);
    check("R6 overflow set", rv, 32'hF);
    do_wr(3'd2, 32'h7);
    do_rd(3'd2, rv);
    check("R6 no clear without bit3", rv, 32'hF);
    do_rd(3'd0, rv);
    check("R8 mirror", rv, 32'h4F);
    do_wr(3'd2, 32'h8);
    do_rd(3'd2, rv);
    check("R6 cleared", rv, 32'h7);
    for (int i = 0; i < 16; i++) begin
      do_rd(3'd1, rv);
      check("R6 rx order", rv, {16'h0, 8'(8'h20 + i), 8'h0});
    end
    do_rd(3'd1, rv);
    check("R5 empty read", rv, 32'h0);
    do_rd(3'd2, rv);
    check("R5 empty unchanged", rv, 32'h3);

    // R1 reset again clears enables and flags
    rx_push(8'h01);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    do_rd(3'd0, rv);
    check("R1 intr after reset", rv, 32'h3);
    do_rd(3'd2, rv);
    check("R1 status after reset", rv, 32'h3);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule